// File: doc/BRIEF.md
# TCP Stream Byte Packer with Port Filter

This block sits between a flow monitor's client-side word stream and an application that consumes TCP payload. Each 32-bit word arrives with frame, header and payload strobes, a 2-bit count of valid payload bytes, an 18-bit flow identifier and new-flow and end-flow flags. Packets whose TCP ports match neither of two elaboration-time filter values still pass through, but all of their stream-data indications are suppressed. For packets that do match, short payload words are merged so that the application sees mostly full 4-byte words. A fragment of up to three bytes is held in one carry register and joined to the next matching packet.

Header words pass through unchanged, and every output appears one clock after its input. When a matching flow terminates, any held fragment goes out in the word slot that would carry the TCP sequence number. The termination packet's own payload then passes through unpacked, so the application has every byte of the flow before the end-flow indication. A packet that starts a new matching flow discards whatever fragment is held.

Top module: `tcp_stream_packer`

## Requirements
- R1: While reset is asserted, every output strobe (data enable, frame start, payload start, frame end, TCP data enable, new flow, end flow) is low and the byte count is zero.
- R2: Frame start, payload start, frame end, data enable and flow ID appear on the outputs exactly one clock after the inputs. Any output word with TCP data enable low carries the input word of the previous clock unchanged.
- R3: At the payload-start word, bits 31:16 are the source port and bits 15:0 the destination port. The packet matches if the source equals `SRC_PORT` or the destination equals `DST_PORT`. For a non-matching packet, TCP data enable, new flow and end flow stay low, and the held fragment is kept unchanged.
- R4: The byte count encodes 00 as one byte, 01 as two, 10 as three and 11 as four, with valid bytes left-aligned from bits 31:24. Bytes outside the count are ignored. The output count is zero whenever output TCP data enable is low.
- R5: Payload bytes of a matching packet that is not a termination packet are appended in arrival order. Each time four bytes have accumulated, one word is emitted with TCP data enable high and count 11, oldest byte in bits 31:24. A payload word that completes no output word is shown with TCP data enable low.
- R6: A fragment of 1–3 bytes left at the end of a matching packet is held and completes the first word of the next matching packet.
- R7: For a matching packet whose new-flow input is high at payload start, output new flow is low on the payload-start word and high from the next word through frame end. The held fragment is discarded at that payload-start word.
- R8: On a matching packet whose end-flow input is high, if 1–3 bytes are held, the output word after payload start carries them left-aligned with zeroed low bytes, TCP data enable high and the matching count. The holding register is then empty.
- R9: Payload words of a matching termination packet pass through with TCP data enable high and their own byte counts.
- R10: Output end flow is high only on the frame-end word of a matching packet whose end-flow input was high at payload start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inData | input | 32 | Input data word |
| inDataEn | input | 1 | Input word valid |
| inSof | input | 1 | Frame start pulse; header follows next cycle |
| inSop | input | 1 | First TCP header word (ports) |
| inEof | input | 1 | Last word of the frame |
| inTde | input | 1 | Word holds TCP payload |
| inBytes | input | 2 | Valid payload bytes minus one |
| inFlowId | input | 18 | Flow identifier |
| inNewFlow | input | 1 | Packet opens a flow |
| inEndFlow | input | 1 | Packet closes a flow |
| outData | output | 32 | Output data word |
| outDataEn | output | 1 | Output word valid |
| outSof | output | 1 | Frame start, delayed |
| outSop | output | 1 | TCP header start, delayed |
| outEof | output | 1 | Frame end, delayed |
| outTde | output | 1 | Output word holds packed payload |
| outBytes | output | 2 | Valid output bytes minus one |
| outFlowId | output | 18 | Flow identifier, delayed |
| outNewFlow | output | 1 | New matching flow |
| outEndFlow | output | 1 | Matching flow ends on this word |

## Verification
On every cycle, the assertions check local invariants. The byte count is zero whenever no payload is flagged. End flow only ever appears on a frame-end word, and new flow never appears on the payload-start word. The three datapath actions are mutually exclusive. A flush empties the holding register, and the holding register is untouched by non-matching payload. Only the bench's scenarios can show byte ordering across packet boundaries, the fragment carried between packets, the discard on a new flow and the exact contents of the sequence-slot flush. The bench checks these against a byte-queue model, cycle by cycle.

// File: rtl/tcp_pack_pkg.sv
package tcp_pack_pkg;
  typedef struct packed {
    logic clearCarry;  // new matching flow: discard held fragment
    logic flushSlot;   // sequence slot of a matching termination packet
    logic packWord;    // payload word to merge into the carry
    logic passData;    // payload word of termination packet, unpacked
    logic newOut;      // drive new-flow on this word
    logic endOut;      // drive end-flow on this word
  } packStrobes_t;
endpackage

// File: rtl/tcp_pack_ctrl.sv
module tcp_pack_ctrl
  import tcp_pack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PORT_W = 16,
  parameter int unsigned SRC_PORT = 80,
  parameter int unsigned DST_PORT = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inDataEn,
  input  logic              inSof,
  input  logic              inSop,
  input  logic              inEof,
  input  logic              inTde,
  input  logic              inNewFlow,
  input  logic              inEndFlow,
  output packStrobes_t      strobes
);
  logic sopHit, portMatch;
  logic pktMatch, pktNew, pktEnd, afterSop;

  assign sopHit    = inDataEn && inSop;
  assign portMatch = (inData[DATA_W-1 -: PORT_W] == PORT_W'(SRC_PORT)) ||
                     (inData[PORT_W-1:0] == PORT_W'(DST_PORT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktMatch <= 1'b0;
      pktNew   <= 1'b0;
      pktEnd   <= 1'b0;
      afterSop <= 1'b0;
    end else if (inSof) begin
      pktMatch <= 1'b0;
      pktNew   <= 1'b0;
      pktEnd   <= 1'b0;
      afterSop <= 1'b0;
    end else if (sopHit) begin
      pktMatch <= portMatch;
      pktNew   <= portMatch && inNewFlow;
      pktEnd   <= portMatch && inEndFlow;
      afterSop <= 1'b1;
    end else if (inDataEn) begin
      afterSop <= 1'b0;
    end
  end

  always_comb begin
    strobes.clearCarry = sopHit && portMatch && inNewFlow;
    strobes.flushSlot  = inDataEn && !inSop && afterSop && pktEnd;
    strobes.packWord   = inDataEn && inTde && pktMatch && !pktEnd;
    strobes.passData   = inDataEn && inTde && pktMatch && pktEnd;
    strobes.newOut     = inDataEn && pktNew;
    strobes.endOut     = inDataEn && inEof && pktEnd;
  end

  // R5: exactly one datapath action at most per word
  a_r5_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.flushSlot, strobes.packWord, strobes.passData}));
  // R7: new flow is never raised on the port word itself
  a_r7_not_on_sop: assert property (@(posedge clk) disable iff (!rstN)
    sopHit |-> !strobes.newOut);
endmodule

// File: rtl/tcp_pack_dp.sv
module tcp_pack_dp
  import tcp_pack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLOW_W = 18
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  packStrobes_t                strobes,
  input  logic [DATA_W-1:0]           inData,
  input  logic                        inDataEn,
  input  logic                        inSof,
  input  logic                        inSop,
  input  logic                        inEof,
  input  logic                        inTde,
  input  logic [$clog2(DATA_W/8)-1:0] inBytes,
  input  logic [FLOW_W-1:0]           inFlowId,
  output logic [DATA_W-1:0]           outData,
  output logic                        outDataEn,
  output logic                        outSof,
  output logic                        outSop,
  output logic                        outEof,
  output logic                        outTde,
  output logic [$clog2(DATA_W/8)-1:0] outBytes,
  output logic [FLOW_W-1:0]           outFlowId,
  output logic                        outNewFlow,
  output logic                        outEndFlow
);
  localparam int LANES   = DATA_W / 8;
  localparam int CNT_W   = $clog2(LANES);
  localparam int CARRY_W = DATA_W - 8;
  localparam int MERGE_W = DATA_W + CARRY_W;

  logic [CARRY_W-1:0] carryBuf;
  logic [CNT_W-1:0]   carryCnt;
  logic [CNT_W:0]     laneCount, shiftLanes;
  logic [CNT_W+1:0]   total, overflow;
  logic [DATA_W-1:0]  inMask;
  logic [MERGE_W-1:0] merged;
  logic               full, flushNow;

  always_comb begin
    laneCount  = {1'b0, inBytes} + (CNT_W+1)'(1);
    shiftLanes = (CNT_W+1)'(LANES) - laneCount;
    inMask     = {DATA_W{1'b1}} << {shiftLanes, 3'b000};
    merged     = {carryBuf, {DATA_W{1'b0}}} |
                 ({inData & inMask, {CARRY_W{1'b0}}} >> {carryCnt, 3'b000});
    total      = (CNT_W+2)'(carryCnt) + (CNT_W+2)'(laneCount);
    overflow   = total - (CNT_W+2)'(LANES);
    full       = total >= (CNT_W+2)'(LANES);
    flushNow   = strobes.flushSlot && (carryCnt != '0);
  end

  // holding register for the partial word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryBuf <= '0;
      carryCnt <= '0;
    end else if (strobes.clearCarry || flushNow) begin
      carryBuf <= '0;
      carryCnt <= '0;
    end else if (strobes.packWord) begin
      if (full) begin
        carryBuf <= merged[CARRY_W-1:0];
        carryCnt <= overflow[CNT_W-1:0];
      end else begin
        carryBuf <= merged[MERGE_W-1 -: CARRY_W];
        carryCnt <= total[CNT_W-1:0];
      end
    end
  end

  // output stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData    <= '0;
      outDataEn  <= 1'b0;
      outSof     <= 1'b0;
      outSop     <= 1'b0;
      outEof     <= 1'b0;
      outTde     <= 1'b0;
      outBytes   <= '0;
      outFlowId  <= '0;
      outNewFlow <= 1'b0;
      outEndFlow <= 1'b0;
    end else begin
      outDataEn  <= inDataEn;
      outSof     <= inSof;
      outSop     <= inSop;
      outEof     <= inEof;
      outFlowId  <= inFlowId;
      outNewFlow <= strobes.newOut;
      outEndFlow <= strobes.endOut;
      outData    <= inData;
      outTde     <= 1'b0;
      outBytes   <= '0;
      if (flushNow) begin
        outData  <= {carryBuf, 8'h00};
        outTde   <= 1'b1;
        outBytes <= carryCnt - CNT_W'(1);
      end else if (strobes.passData) begin
        outTde   <= 1'b1;
        outBytes <= inBytes;
      end else if (strobes.packWord && full) begin
        outData  <= merged[MERGE_W-1 -: DATA_W];
        outTde   <= 1'b1;
        outBytes <= {CNT_W{1'b1}};
      end
    end
  end

  // R4: no byte count without payload
  a_r4_count_idle: assert property (@(posedge clk) disable iff (!rstN)
    !outTde |-> (outBytes == '0));
  // R8: a flush leaves the holding register empty and emits data
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flushNow |=> (carryCnt == '0) && outTde);
  // R3: payload of a non-matching packet leaves the fragment alone
  a_r3_hold_carry: assert property (@(posedge clk) disable iff (!rstN)
    (inDataEn && inTde && !strobes.packWord && !strobes.passData) |=>
      $stable(carryCnt) && $stable(carryBuf) && !outTde);
  // R10: end flow only on a frame-end word
  a_r10_end_on_eof: assert property (@(posedge clk) disable iff (!rstN)
    outEndFlow |-> outEof);
endmodule

// File: rtl/tcp_stream_packer.sv
module tcp_stream_packer
  import tcp_pack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLOW_W = 18,
  parameter int PORT_W = 16,
  parameter int unsigned SRC_PORT = 80,
  parameter int unsigned DST_PORT = 25
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [DATA_W-1:0]           inData,
  input  logic                        inDataEn,
  input  logic                        inSof,
  input  logic                        inSop,
  input  logic                        inEof,
  input  logic                        inTde,
  input  logic [$clog2(DATA_W/8)-1:0] inBytes,
  input  logic [FLOW_W-1:0]           inFlowId,
  input  logic                        inNewFlow,
  input  logic                        inEndFlow,
  output logic [DATA_W-1:0]           outData,
  output logic                        outDataEn,
  output logic                        outSof,
  output logic                        outSop,
  output logic                        outEof,
  output logic                        outTde,
  output logic [$clog2(DATA_W/8)-1:0] outBytes,
  output logic [FLOW_W-1:0]           outFlowId,
  output logic                        outNewFlow,
  output logic                        outEndFlow
);
  packStrobes_t strobes;

  tcp_pack_ctrl #(
    .DATA_W(DATA_W), .PORT_W(PORT_W), .SRC_PORT(SRC_PORT), .DST_PORT(DST_PORT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inData(inData), .inDataEn(inDataEn),
    .inSof(inSof), .inSop(inSop), .inEof(inEof), .inTde(inTde),
    .inNewFlow(inNewFlow), .inEndFlow(inEndFlow), .strobes(strobes)
  );

  tcp_pack_dp #(.DATA_W(DATA_W), .FLOW_W(FLOW_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .inData(inData), .inDataEn(inDataEn), .inSof(inSof), .inSop(inSop),
    .inEof(inEof), .inTde(inTde), .inBytes(inBytes), .inFlowId(inFlowId),
    .outData(outData), .outDataEn(outDataEn), .outSof(outSof),
    .outSop(outSop), .outEof(outEof), .outTde(outTde), .outBytes(outBytes),
    .outFlowId(outFlowId), .outNewFlow(outNewFlow), .outEndFlow(outEndFlow)
  );
endmodule

// File: tb/tcp_stream_packer_tb.sv
module tcp_stream_packer_tb;
  localparam int SRC = 80;
  localparam int DST = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] inData = '0;
  logic inDataEn = 0, inSof = 0, inSop = 0, inEof = 0, inTde = 0;
  logic [1:0] inBytes = '0;
  logic [17:0] inFlowId = '0;
  logic inNewFlow = 0, inEndFlow = 0;
  logic [31:0] outData;
  logic outDataEn, outSof, outSop, outEof, outTde, outNewFlow, outEndFlow;
  logic [1:0] outBytes;
  logic [17:0] outFlowId;

  always #10 clk = ~clk;

  tcp_stream_packer #(.SRC_PORT(SRC), .DST_PORT(DST)) u_dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inDataEn(inDataEn),
    .inSof(inSof), .inSop(inSop), .inEof(inEof), .inTde(inTde),
    .inBytes(inBytes), .inFlowId(inFlowId), .inNewFlow(inNewFlow),
    .inEndFlow(inEndFlow), .outData(outData), .outDataEn(outDataEn),
    .outSof(outSof), .outSop(outSop), .outEof(outEof), .outTde(outTde),
    .outBytes(outBytes), .outFlowId(outFlowId), .outNewFlow(outNewFlow),
    .outEndFlow(outEndFlow)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [7:0] q[$];
  bit mMatch = 0, mNew = 0, mEnd = 0, mAfter = 0;
  bit expValid = 0;
  logic [22:0] expStrb;
  logic [31:0] expData;
  logic expTde, expNew, expEnd;
  logic [1:0] expBytes;
  string expTag;
  int byteCtr = 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [22:0] actStrb;
    actStrb = {outSof, outSop, outEof, outDataEn, outFlowId, outTde};
    chk(actStrb[22:1] == expStrb[22:1], "R2", "strobes", actStrb[22:1], expStrb[22:1]);
    chk(outData == expData, expTag, "data", outData, expData);
    chk(outTde == expTde, expTag, "tde", outTde, expTde);
    chk(outBytes == expBytes, "R4", "bytes", outBytes, expBytes);
    chk(outNewFlow == expNew, "R7", "newflow", outNewFlow, expNew);
    chk(outEndFlow == expEnd, "R10", "endflow", outEndFlow, expEnd);
  endtask

  task automatic cyc(input bit sof, input bit sop, input bit eof, input bit de,
                     input bit tde, input logic [1:0] by, input logic [31:0] d,
                     input logic [17:0] fid, input bit nf, input bit ef);
    bit m, carried;
    int k;
    @(negedge clk);
    if (expValid) compare();
    inSof = sof; inSop = sop; inEof = eof; inDataEn = de; inTde = tde;
    inBytes = by; inData = d; inFlowId = fid; inNewFlow = nf; inEndFlow = ef;
    expStrb = {sof, sop, eof, de, fid, 1'b0};
    expData = d; expTde = 0; expBytes = 0; expTag = "R2";
    expNew = de && mNew;
    expEnd = de && mEnd && eof;
    if (de && !sop && mAfter && mEnd && q.size() > 0) begin
      expTag = "R8";
      expData = '0;
      foreach (q[i]) expData[31-8*i -: 8] = q[i];
      expTde = 1; expBytes = 2'(q.size() - 1);
      q.delete();
    end else if (de && tde && mMatch && mEnd) begin
      expTag = "R9"; expTde = 1; expBytes = by;
    end else if (de && tde && mMatch) begin
      carried = q.size() > 0;
      k = int'(by) + 1;
      for (int j = 0; j < k; j++) q.push_back(d[31-8*j -: 8]);
      expTag = "R5";
      if (q.size() >= 4) begin
        expTag = carried ? "R6" : "R5";
        for (int j = 0; j < 4; j++) expData[31-8*j -: 8] = q.pop_front();
        expTde = 1; expBytes = 2'b11;
      end
    end else if (de && tde) begin
      expTag = "R3";
    end
    if (sof) begin
      mMatch = 0; mNew = 0; mEnd = 0; mAfter = 0;
    end else if (de && sop) begin
      m = (d[31:16] == 16'(SRC)) || (d[15:0] == 16'(DST));
      mMatch = m; mNew = m && nf; mEnd = m && ef; mAfter = 1;
      if (m && nf) q.delete();
    end else if (de) begin
      mAfter = 0;
    end
    expValid = 1;
  endtask

  task automatic sendPacket(input int src, input int dst, input logic [17:0] fid,
                            input bit nf, input bit ef, input int nb);
    int words, k;
    logic [31:0] w;
    words = (nb + 3) / 4;
    cyc(1, 0, 0, 0, 0, 0, 32'h0, fid, nf, ef);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 0, 0, 32'h4500_0000 + i, fid, nf, ef);
    cyc(0, 1, 0, 1, 0, 0, {16'(src), 16'(dst)}, fid, nf, ef);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0, 32'h5EC0_0000 + i, fid, nf, ef);
    cyc(0, 0, nb == 0, 1, 0, 0, 32'hC5C5_0000, fid, nf, ef);
    for (int wi = 0; wi < words; wi++) begin
      k = (nb - 4*wi > 4) ? 4 : nb - 4*wi;
      w = 32'hEEEE_EEEE;  // filler in unused lanes (R4)
      for (int j = 0; j < k; j++) begin
        w[31-8*j -: 8] = 8'(byteCtr);
        byteCtr++;
      end
      cyc(0, 0, wi == words - 1, 1, 1, 2'(k - 1), w, fid, nf, ef);
    end
    cyc(0, 0, 0, 0, 0, 0, 32'h0, fid, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!outDataEn && !outSof && !outSop && !outEof && !outTde, "R1", "strobes", 0, 0);
    chk(!outNewFlow && !outEndFlow && outBytes == 0, "R1", "flags", 0, 0);
    rstN = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, 32'h0, 0, 0, 0);
    sendPacket(SRC, 1000, 18'd1, 1, 0, 8);   // R5, R7: full words, new flow
    sendPacket(SRC, 1000, 18'd1, 0, 0, 6);   // R5: leaves 2 bytes held
    sendPacket(1234, 4321, 18'd2, 1, 0, 7);  // R3: non-matching, new ignored
    sendPacket(5000, DST, 18'd1, 0, 0, 3);   // R3/R6: dst match, carry completes word
    sendPacket(SRC, 7, 18'd1, 0, 0, 0);      // no payload
    sendPacket(SRC, 7, 18'd1, 0, 0, 1);      // R6: two bytes held
    sendPacket(SRC, 7, 18'd1, 0, 1, 5);      // R8 flush, R9 pass, R10 end
    sendPacket(SRC, 7, 18'd3, 1, 0, 3);      // three bytes held
    sendPacket(SRC, 9, 18'd4, 1, 0, 2);      // R7: held bytes discarded
    sendPacket(SRC, 9, 18'd4, 0, 1, 0);      // R8: two-byte flush
    sendPacket(SRC, 9, 18'd4, 0, 1, 2);      // R8: nothing held, no flush
    sendPacket(1, 2, 18'd5, 0, 1, 4);        // R10: non-matching end ignored
    cyc(0, 0, 0, 0, 0, 0, 32'h0, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule